// File: doc/BRIEF.md
# Per-Channel Load Fault Detector

This block supervises one low-side power switch channel. It receives an active-low switch request and three comparator flags that have already been turned into synchronous digital levels. The flags report a drain-source voltage above the overload threshold, below the open-load threshold, and below the short-to-ground threshold. From these it drives the gate enable of the power stage and keeps a 2-bit fault code. A one-cycle strobe marks every write of the code.

The fault that can be detected depends on the switch state. While the switch is requested on, the only fault it looks for is a sustained overload, which also turns the switch off. After such a shutdown the switch stays off until the request has been withdrawn and then given again. While the switch is requested off, the block looks for two faults, open load and short to ground, and each needs its own minimum dwell time. All dwell times are counted in cycles of the reference clock. An undervoltage indication clears the code and forces the switch off, and so does the synchronous reset.

Top module: `ls_fault_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `gate_en_o` is 0, `fault_code_o` is 00 and `fault_stb_o` is 0. Every dwell count restarts.
- R2: When no lockout is pending, `gate_en_o` equals the request (`ctrl_n_i` low means on) sampled at the previous clock edge.
- R3: If `gate_en_o` is 1, the request is on and `ov_flag_i` is 1 for OVL_CYC consecutive edges, then after the last of those edges `fault_code_o` is 01 (overload), `fault_stb_o` is 1 and `gate_en_o` is 0.
- R4: After an overload shutdown, `gate_en_o` stays 0 while the request stays on, even if the flag clears. It returns to 1 one cycle after the request is seen on again, provided the request was seen off at one or more edges in between.
- R5: With the request off, if `ol_flag_i` is 1 for OPEN_CYC consecutive edges, the code becomes 10 (open load) after the last of those edges.
- R6: With the request off, if `sh_flag_i` is 1 for SHORT_CYC consecutive edges, the code becomes 11 (short to ground) after the last of those edges.
- R7: A newly qualified fault replaces whatever code is already latched.
- R8: An open-load qualification that falls on an edge where `sh_flag_i` is 1 writes nothing. When both faults qualify on the same edge, the code written is 11.
- R9: `fault_stb_o` is 1 for exactly the one cycle after each code write, and the code written is never 00. `clr_i` sets the code to 00. When a write and a clear fall on the same edge, the write wins.
- R10: A dwell count restarts whenever its flag drops, and whenever the request changes state.
- R11: While `uv_i` is 1, `gate_en_o` and `fault_code_o` are forced to 0 and every dwell count restarts. Once `uv_i` is released, an active request turns the switch on one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all dwell counting |
| rst_n | input | 1 | Synchronous reset, active low |
| uv_i | input | 1 | Supply undervoltage indication, active high |
| ctrl_n_i | input | 1 | Switch request, low = on |
| ov_flag_i | input | 1 | Drain-source voltage above overload threshold |
| ol_flag_i | input | 1 | Drain-source voltage below open-load threshold |
| sh_flag_i | input | 1 | Drain-source voltage below short-to-ground threshold |
| clr_i | input | 1 | Clears the latched fault code |
| gate_en_o | output | 1 | Gate enable of the power switch |
| fault_code_o | output | 2 | Latched fault: 00 none, 01 overload, 10 open load, 11 short |
| fault_stb_o | output | 1 | One-cycle pulse on every fault code write |

## Verification
The bench watches the ports for a dwell counter that is off by one, and such an error moves the strobe and the code change by one cycle relative to the end of the qualifying window. Directed runs stop one edge short of each limit and then check the edge that should qualify. A lockout flag stuck set or stuck clear shows up on `gate_en_o` one cycle after the request returns. A wrong priority between short and open load, or a lost write over a clear, changes `fault_code_o` on the very edge concerned. A cycle-accurate reference model compares every output on every cycle of a random run.

// File: rtl/lsfd_pkg.sv
// Package: shared fault code type for the load fault detector.
// Assumes nothing beyond a 2-bit code space.
package lsfd_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_OVLD  = 2'b01,
        FLT_OPEN  = 2'b10,
        FLT_SHORT = 2'b11
    } fault_e;
endpackage

// File: rtl/lsfd_dwell.sv
// Dwell timer: counts consecutive edges with cond_i high and reports the
// edge on which the count reaches LIMIT. The count saturates there, so the
// report is a single pulse for each unbroken run.
// Assumes LIMIT >= 1 and that cond_i is a synchronous level.
module lsfd_dwell #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic hit_o
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    // Count the run length, restarting when the condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !cond_i) begin
            cnt_q <= '0;
        end else if (cnt_q != W'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualify on the LIMIT-th consecutive edge.
    assign hit_o = cond_i && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/lsfd_gate.sv
// Gate control: follows the request one cycle late and holds the switch off
// after an overload until the request has been seen off.
// Assumes kill_i already merges every forced-off source other than reset.
module lsfd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_i,
    input  logic req_i,
    input  logic ovl_hit_i,
    output logic gate_o
);
    logic lock_q;
    logic gate_q;

    // Lockout flag and registered gate enable.
    always_ff @(posedge clk) begin
        if (!rst_n || kill_i) begin
            lock_q <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            lock_q <= ovl_hit_i | (lock_q & req_i);
            gate_q <= req_i & ~lock_q & ~ovl_hit_i;
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/lsfd_latch.sv
// Fault latch: picks the fault to record, writes it over the old code,
// pulses a strobe and lets an external clear zero the code.
// Assumes that at most the overload hit or the inactive-mode hits are set
// in any one cycle.
module lsfd_latch
    import lsfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill_i,
    input  logic       clr_i,
    input  logic       ovl_hit_i,
    input  logic       open_hit_i,
    input  logic       short_hit_i,
    input  logic       short_now_i,
    output logic [1:0] code_o,
    output logic       stb_o
);
    fault_e code_q;
    fault_e code_nxt;
    logic   stb_q;
    logic   wr;

    // Choose the fault to write; a short overrides a concurrent open load.
    always_comb begin
        wr       = 1'b1;
        code_nxt = FLT_NONE;
        if (ovl_hit_i) begin
            code_nxt = FLT_OVLD;
        end else if (short_hit_i) begin
            code_nxt = FLT_SHORT;
        end else if (open_hit_i && !short_now_i) begin
            code_nxt = FLT_OPEN;
        end else begin
            wr = 1'b0;
        end
    end

    // Latch the code and strobe; writes take precedence over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || kill_i) begin
            code_q <= FLT_NONE;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= wr;
            if (wr) begin
                code_q <= code_nxt;
            end else if (clr_i) begin
                code_q <= FLT_NONE;
            end
        end
    end

    assign code_o = code_q;
    assign stb_o  = stb_q;
endmodule

// File: rtl/ls_fault_guard.sv
// Per-channel load fault detector top. It gates the comparator flags by the
// switch state, qualifies each flag with its own dwell timer, controls the
// gate and latches the fault code.
// Assumes every input is synchronous to clk.
module ls_fault_guard #(
    parameter int unsigned OVL_CYC   = 16,
    parameter int unsigned OPEN_CYC  = 50,
    parameter int unsigned SHORT_CYC = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_i,
    input  logic       ctrl_n_i,
    input  logic       ov_flag_i,
    input  logic       ol_flag_i,
    input  logic       sh_flag_i,
    input  logic       clr_i,
    output logic       gate_en_o,
    output logic [1:0] fault_code_o,
    output logic       fault_stb_o
);
    localparam int unsigned NTMR = 3;
    localparam int unsigned LIMS [NTMR] = '{OVL_CYC, OPEN_CYC, SHORT_CYC};

    logic            req;
    logic            live;
    logic [NTMR-1:0] cond;
    logic [NTMR-1:0] hit;

    assign req  = ~ctrl_n_i;
    assign live = ~uv_i;

    // Mode-dependent qualifying conditions (index 0 overload, 1 open, 2 short).
    always_comb begin
        cond[0] = live & gate_en_o & req & ov_flag_i;
        cond[1] = live & ~req & ol_flag_i;
        cond[2] = live & ~req & sh_flag_i;
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        lsfd_dwell #(.LIMIT(LIMS[g])) u_dwell (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (cond[g]),
            .hit_o  (hit[g])
        );
    end

    lsfd_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_i    (uv_i),
        .req_i     (req),
        .ovl_hit_i (hit[0]),
        .gate_o    (gate_en_o)
    );

    lsfd_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill_i      (uv_i),
        .clr_i       (clr_i),
        .ovl_hit_i   (hit[0]),
        .open_hit_i  (hit[1]),
        .short_hit_i (hit[2]),
        .short_now_i (sh_flag_i),
        .code_o      (fault_code_o),
        .stb_o       (fault_stb_o)
    );
endmodule

// File: rtl/lsfd_checker.sv
// Checker: port-level properties of the load fault detector, bound to the top.
module lsfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_i,
    input logic       ctrl_n_i,
    input logic       sh_flag_i,
    input logic       gate_en_o,
    input logic [1:0] fault_code_o,
    input logic       fault_stb_o
);
    p_uv_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (!gate_en_o && fault_code_o == 2'b00));

    p_rise_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> $past(!ctrl_n_i));

    p_ovld_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb_o && fault_code_o == 2'b01) |-> !gate_en_o);

    p_open_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb_o && fault_code_o == 2'b10) |-> ($past(ctrl_n_i) && !$past(sh_flag_i)));

    p_short_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb_o && fault_code_o == 2'b11) |-> ($past(ctrl_n_i) && $past(sh_flag_i)));

    p_code_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_code_o) |-> (fault_stb_o || fault_code_o == 2'b00));

    p_stb_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb_o |-> fault_code_o != 2'b00);
endmodule

bind ls_fault_guard lsfd_checker u_chk (.*);

// File: tb/ls_fault_guard_test.sv
module ls_fault_guard_test;
    localparam int OVL = 4;
    localparam int OPN = 12;
    localparam int SHT = 7;

    logic clk = 1'b0;
    logic rst_n, uv_i, ctrl_n_i, ov_flag_i, ol_flag_i, sh_flag_i, clr_i;
    logic gate_en_o, fault_stb_o;
    logic [1:0] fault_code_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_lock, m_gate, m_stb;
    bit [1:0] m_code;
    int k_ov, k_ol, k_sh;

    always #4 clk = ~clk;

    ls_fault_guard #(.OVL_CYC(OVL), .OPEN_CYC(OPN), .SHORT_CYC(SHT)) uut (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Next-state of the requirement model from the current inputs.
    task automatic model_update();
        bit act, c_ov, c_ol, c_sh, h_ov, h_ol, h_sh, wr;
        bit [1:0] nc;
        act  = !ctrl_n_i;
        c_ov = m_gate && act && ov_flag_i && !uv_i;
        c_ol = !act && ol_flag_i && !uv_i;
        c_sh = !act && sh_flag_i && !uv_i;
        h_ov = c_ov && (k_ov == OVL - 1);
        h_ol = c_ol && (k_ol == OPN - 1);
        h_sh = c_sh && (k_sh == SHT - 1);
        k_ov = (!rst_n || !c_ov) ? 0 : (k_ov < OVL ? k_ov + 1 : k_ov);
        k_ol = (!rst_n || !c_ol) ? 0 : (k_ol < OPN ? k_ol + 1 : k_ol);
        k_sh = (!rst_n || !c_sh) ? 0 : (k_sh < SHT ? k_sh + 1 : k_sh);
        if (!rst_n || uv_i) begin
            m_lock = 0; m_gate = 0; m_code = 0; m_stb = 0;
        end else begin
            wr = 1; nc = 0;
            if (h_ov) nc = 2'b01;
            else if (h_sh) nc = 2'b11;
            else if (h_ol && !sh_flag_i) nc = 2'b10;
            else wr = 0;
            m_gate = act && !m_lock && !h_ov;
            m_lock = h_ov || (m_lock && act);
            m_stb  = wr;
            if (wr) m_code = nc;
            else if (clr_i) m_code = 0;
        end
    endtask

    task automatic tick();
        model_update();
        @(posedge clk);
        #1;
        check("R2 model gate", gate_en_o, m_gate);
        check("R7 model code", fault_code_o, m_code);
        check("R9 model strobe", fault_stb_o, m_stb);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; uv_i = 0; ctrl_n_i = 1; ov_flag_i = 0; ol_flag_i = 0;
        sh_flag_i = 0; clr_i = 0;
        #1;
        ticks(3);
        check("R1 gate", gate_en_o, 0);
        check("R1 code", fault_code_o, 0);
        check("R1 strobe", fault_stb_o, 0);
        rst_n = 1;

        ctrl_n_i = 0; tick();
        check("R2 on", gate_en_o, 1);

        ov_flag_i = 1; ticks(OVL - 1);
        check("R3 early code", fault_code_o, 0);
        check("R3 early gate", gate_en_o, 1);
        tick();
        check("R3 code", fault_code_o, 1);
        check("R3 strobe", fault_stb_o, 1);
        check("R3 gate off", gate_en_o, 0);
        tick();
        check("R9 one cycle", fault_stb_o, 0);

        ov_flag_i = 0; ticks(3);
        check("R4 held off", gate_en_o, 0);
        ctrl_n_i = 1; tick();
        ctrl_n_i = 0; tick();
        check("R4 rearmed", gate_en_o, 1);

        ctrl_n_i = 1; tick();
        ol_flag_i = 1; ticks(OPN - 1);
        check("R5 early", fault_code_o, 1);
        tick();
        check("R5 open", fault_code_o, 2);
        check("R7 overwrite strobe", fault_stb_o, 1);

        ol_flag_i = 0; tick();
        sh_flag_i = 1; ol_flag_i = 1; ticks(SHT - 1);
        check("R6 early", fault_code_o, 2);
        tick();
        check("R6 short", fault_code_o, 3);
        ticks(OPN);
        check("R8 short kept", fault_code_o, 3);
        check("R8 no strobe", fault_stb_o, 0);

        sh_flag_i = 0; ol_flag_i = 0; tick();
        clr_i = 1; tick(); clr_i = 0;
        check("R9 clear", fault_code_o, 0);

        ol_flag_i = 1; ticks(OPN - 1);
        clr_i = 1; tick(); clr_i = 0;
        check("R9 write wins", fault_code_o, 2);
        ol_flag_i = 0; clr_i = 1; tick(); clr_i = 0;

        ol_flag_i = 1; ticks(OPN - 1);
        ol_flag_i = 0; tick();
        ol_flag_i = 1; ticks(OPN - 1);
        check("R10 drop restart", fault_code_o, 0);
        tick();
        check("R10 full run", fault_code_o, 2);
        clr_i = 1; ol_flag_i = 0; tick(); clr_i = 0;
        ol_flag_i = 1; ticks(OPN - 1);
        ctrl_n_i = 0; tick();
        ctrl_n_i = 1; ticks(OPN - 1);
        check("R10 mode restart", fault_code_o, 0);
        ol_flag_i = 0; tick();

        ctrl_n_i = 0; ov_flag_i = 1; ticks(OVL + 1);
        ov_flag_i = 0; ctrl_n_i = 1; tick();
        ctrl_n_i = 0; tick();
        check("R11 pre gate", gate_en_o, 1);
        check("R11 pre code", fault_code_o, 1);
        uv_i = 1; tick();
        check("R11 gate", gate_en_o, 0);
        check("R11 code", fault_code_o, 0);
        tick();
        uv_i = 0; tick();
        check("R11 release", gate_en_o, 1);

        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) ctrl_n_i = ~ctrl_n_i;
            if ($urandom_range(0, 9) == 0)  ov_flag_i = ~ov_flag_i;
            if ($urandom_range(0, 15) == 0) ol_flag_i = ~ol_flag_i;
            if ($urandom_range(0, 17) == 0) sh_flag_i = ~sh_flag_i;
            clr_i = ($urandom_range(0, 49) == 0);
            uv_i  = ($urandom_range(0, 199) == 0);
            rst_n = ($urandom_range(0, 499) != 0);
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule